// File: doc/BRIEF.md
# SMRAM Window Controller with Lock

This block holds the control byte that governs system-management memory in a host memory controller. Two fields in that byte open three kinds of window. The first is a low compatibility window over the 128 KB range at 0xA0000. The second is a 128 KB high alias at 0xFEEA0000 that lands on the same DRAM. The third is a window at the top of installed memory, which can also be reached through a host alias placed 256 MB above that top. A sticky lock bit freezes the control byte and the two memory-size bytes until the next reset.

Each cycle the block looks at one incoming address, together with the system-management-mode flag. It reports which window, if any, claims the address and gives the DRAM address that the access should use. Configuration reads and writes use a small byte-wide port. Reads are combinational.

Top module: `smram_ctl`

## Requirements
- R1: After reset the control byte (config offset 0x70) and the size bytes (offsets 0x52 and 0x54) read as 0x00, and no window hit is reported for any address or mode flag.
- R2: While unlocked, a write to offset 0x70 stores the written byte with bit 0 forced to 0. Bits [3:2] hold the low mode, bits [5:4] hold the upper mode and bit 1 is the lock.
- R3: Low mode 1 claims addresses 0xA0000 to 0xBFFFF whatever the mode flag is. The DRAM address equals the input address.
- R4: Low mode 0 and low mode 2 never claim the low window. Low mode 3 claims it only while the mode flag is high.
- R5: Any nonzero upper mode claims 0xFEEA0000 to 0xFEEBFFFF while the mode flag is high. The DRAM address is 0xA0000 plus the offset into that range.
- R6: Upper mode 2 claims a 1 MB window starting at top of memory, only while the mode flag is high. The DRAM address equals the input address.
- R7: Upper mode 3 makes the top-of-memory window 512 KB. Upper mode 1 opens no top-of-memory window.
- R8: When the top-of-memory window is open, the same window is also claimed at top of memory plus 0x1000_0000. The DRAM address is the input address minus 0x1000_0000.
- R9: While bit 1 of the control byte is set, a write to offset 0x70 can change only bit 2. The upper mode and every other bit keep their values.
- R10: Once set, the lock stays set through any write and is cleared only by reset.
- R11: While unlocked, a write to offset 0x52 stores all 8 bits and a write to offset 0x54 stores bits [3:0] (the upper bits read as 0). While locked, writes to either offset are ignored.
- R12: At most one hit output is high at a time. When none is high, the DRAM address output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr |
| tom | input | 32 | Top of installed memory, byte address |
| smm_active | input | 1 | Processor is in system-management mode |
| mem_addr | input | 32 | Host address to decode |
| hit_low | output | 1 | Low compatibility window claims mem_addr |
| hit_high | output | 1 | High alias window claims mem_addr |
| hit_top | output | 1 | Top-of-memory window claims mem_addr |
| hit_alias | output | 1 | Host alias of the top-of-memory window claims mem_addr |
| dram_addr | output | 32 | Remapped DRAM address for the claiming window |

## Verification
The decode is combinational, so a wrong control byte shows up on the hit outputs and dram_addr in the very cycle after the write. It also shows up in the read-back at offset 0x70. Lock faults are silent until a later write. For that reason the bench writes after locking and then reads back and decodes before anything else changes. A size byte that was wrongly updated is visible only through its own read-back.

// File: rtl/smram_ctl.sv
module smram_ctl #(
  parameter int          AW         = 32,
  parameter logic [31:0] LOW_BASE   = 32'h000A_0000,
  parameter logic [31:0] HIGH_BASE  = 32'hFEEA_0000,
  parameter logic [31:0] WIN_SIZE   = 32'h0002_0000,
  parameter logic [31:0] ALIAS_OFS  = 32'h1000_0000,
  parameter logic [31:0] TOP_BIG    = 32'h0010_0000,
  parameter logic [31:0] TOP_SMALL  = 32'h0008_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_addr,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_rdata,
  input  logic [AW-1:0] tom,
  input  logic          smm_active,
  input  logic [AW-1:0] mem_addr,
  output logic          hit_low,
  output logic          hit_high,
  output logic          hit_top,
  output logic          hit_alias,
  output logic [AW-1:0] dram_addr
);
  localparam logic [7:0] A_CTL  = 8'h70;
  localparam logic [7:0] A_SZLO = 8'h52;
  localparam logic [7:0] A_SZHI = 8'h54;

  logic [7:0] ctl_q, size_lo_q, size_hi_q;
  logic       locked;
  logic [1:0] low_mode, up_mode;

  assign locked   = ctl_q[1];
  assign low_mode = ctl_q[3:2];
  assign up_mode  = ctl_q[5:4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      size_lo_q <= '0;
      size_hi_q <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == A_CTL) begin
        if (locked) ctl_q <= {ctl_q[7:3], cfg_wdata[2], ctl_q[1:0]};
        else        ctl_q <= {cfg_wdata[7:1], 1'b0};
      end
      if (cfg_addr == A_SZLO && !locked) size_lo_q <= cfg_wdata;
      if (cfg_addr == A_SZHI && !locked) size_hi_q <= {4'h0, cfg_wdata[3:0]};
    end
  end

  always_comb begin
    case (cfg_addr)
      A_CTL:   cfg_rdata = ctl_q;
      A_SZLO:  cfg_rdata = size_lo_q;
      A_SZHI:  cfg_rdata = size_hi_q;
      default: cfg_rdata = '0;
    endcase
  end

  logic [AW:0] a_x, top_lo, top_hi, al_lo, al_hi;
  logic [AW-1:0] top_size;
  logic in_low, in_high, low_ok;

  assign a_x      = {1'b0, mem_addr};
  assign top_size = (up_mode == 2'd3) ? TOP_SMALL[AW-1:0] : TOP_BIG[AW-1:0];
  assign top_lo   = {1'b0, tom};
  assign top_hi   = top_lo + {1'b0, top_size};
  assign al_lo    = top_lo + {1'b0, ALIAS_OFS[AW-1:0]};
  assign al_hi    = al_lo + {1'b0, top_size};

  assign in_low  = mem_addr >= LOW_BASE[AW-1:0]  && mem_addr < LOW_BASE[AW-1:0] + WIN_SIZE[AW-1:0];
  assign in_high = mem_addr >= HIGH_BASE[AW-1:0] && mem_addr < HIGH_BASE[AW-1:0] + WIN_SIZE[AW-1:0];
  assign low_ok  = (low_mode == 2'd1) || (low_mode == 2'd3 && smm_active);

  assign hit_low   = in_low && low_ok;
  assign hit_high  = in_high && smm_active && up_mode != 2'd0;
  assign hit_top   = smm_active && up_mode[1] && a_x >= top_lo && a_x < top_hi && !hit_low && !hit_high;
  assign hit_alias = smm_active && up_mode[1] && a_x >= al_lo && a_x < al_hi
                     && !hit_low && !hit_high && !hit_top;

  always_comb begin
    if (hit_low)        dram_addr = mem_addr;
    else if (hit_high)  dram_addr = mem_addr - HIGH_BASE[AW-1:0] + LOW_BASE[AW-1:0];
    else if (hit_top)   dram_addr = mem_addr;
    else if (hit_alias) dram_addr = mem_addr - ALIAS_OFS[AW-1:0];
    else                dram_addr = '0;
  end
endmodule

// File: rtl/smram_ctl_chk.sv
module smram_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctl_q,
  input logic [7:0] size_lo_q,
  input logic [7:0] size_hi_q,
  input logic       hit_low,
  input logic       hit_high,
  input logic       hit_top,
  input logic       hit_alias
);
  a_r2_bit0_zero: assert property (@(posedge clk) disable iff (!rst_n) ctl_q[0] == 1'b0);
  a_r4_mode2_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[3:2] == 2'd2 || ctl_q[3:2] == 2'd0) |-> !hit_low);
  a_r7_mode1_no_top: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[5:4] == 2'd1) |-> !(hit_top || hit_alias));
  a_r9_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[1] |=> ((ctl_q & 8'hFB) == ($past(ctl_q) & 8'hFB)));
  a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n) ctl_q[1] |=> ctl_q[1]);
  a_r11_size_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[1] |=> ($stable(size_lo_q) && $stable(size_hi_q)));
  a_r12_one_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_low, hit_high, hit_top, hit_alias}));
endmodule

bind smram_ctl smram_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .size_lo_q(size_lo_q), .size_hi_q(size_hi_q),
  .hit_low(hit_low), .hit_high(hit_high), .hit_top(hit_top), .hit_alias(hit_alias)
);

// File: tb/sim_smram_ctl.sv
module sim_smram_ctl;
  logic clk = 0, rst_n = 0, cfg_we = 0, smm_active = 0;
  logic [7:0] cfg_addr = 0, cfg_wdata = 0, cfg_rdata;
  logic [31:0] tom = 32'h0800_0000, mem_addr = 0, dram_addr;
  logic hit_low, hit_high, hit_top, hit_alias;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  smram_ctl u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tom(tom), .smm_active(smm_active),
    .mem_addr(mem_addr), .hit_low(hit_low), .hit_high(hit_high), .hit_top(hit_top),
    .hit_alias(hit_alias), .dram_addr(dram_addr));

  // {ctl byte, smm, addr, hits{low,high,top,alias}, dram}
  localparam int NV = 19;
  localparam logic [76:0] VEC [NV] = '{
    {8'h05, 1'b0, 32'h000A_0000, 4'b1000, 32'h000A_0000},  // R2 R3
    {8'h04, 1'b0, 32'h000B_FFFF, 4'b1000, 32'h000B_FFFF},  // R3
    {8'h04, 1'b0, 32'h000C_0000, 4'b0000, 32'h0},          // R12
    {8'h04, 1'b0, 32'h0009_FFFF, 4'b0000, 32'h0},          // R12
    {8'h08, 1'b1, 32'h000A_1234, 4'b0000, 32'h0},          // R4
    {8'h0C, 1'b0, 32'h000A_1234, 4'b0000, 32'h0},          // R4
    {8'h0C, 1'b1, 32'h000A_1234, 4'b1000, 32'h000A_1234},  // R4
    {8'h11, 1'b1, 32'hFEEA_0010, 4'b0100, 32'h000A_0010},  // R5
    {8'h10, 1'b1, 32'hFEEC_0000, 4'b0000, 32'h0},          // R5
    {8'h10, 1'b0, 32'hFEEA_0010, 4'b0000, 32'h0},          // R5
    {8'h10, 1'b1, 32'h0800_0000, 4'b0000, 32'h0},          // R7
    {8'h20, 1'b1, 32'h080F_FFFF, 4'b0010, 32'h080F_FFFF},  // R6
    {8'h20, 1'b1, 32'h0810_0000, 4'b0000, 32'h0},          // R6
    {8'h30, 1'b1, 32'h0807_FFFF, 4'b0010, 32'h0807_FFFF},  // R7
    {8'h30, 1'b1, 32'h0808_0000, 4'b0000, 32'h0},          // R7
    {8'h20, 1'b1, 32'h1800_0040, 4'b0001, 32'h0800_0040},  // R8
    {8'h30, 1'b1, 32'h1808_0000, 4'b0000, 32'h0},          // R8
    {8'h20, 1'b0, 32'h0800_0000, 4'b0000, 32'h0},          // R6
    {8'h3C, 1'b1, 32'hFEEA_0000, 4'b0100, 32'h000A_0000}   // R5
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1 chk(req, {24'h0, cfg_rdata}, {24'h0, exp});
  endtask

  task automatic look(input string req, input logic s, input logic [31:0] a,
                      input logic [3:0] eh, input logic [31:0] ed);
    @(negedge clk);
    smm_active = s; mem_addr = a;
    #1;
    chk(req, {28'h0, hit_low, hit_high, hit_top, hit_alias}, {28'h0, eh});
    chk(req, dram_addr, ed);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd("R1", 8'h70, 8'h00);
    rd("R1", 8'h52, 8'h00);
    rd("R1", 8'h54, 8'h00);
    look("R1", 1'b1, 32'h000A_0000, 4'b0000, 32'h0);
    look("R1", 1'b1, 32'hFEEA_0000, 4'b0000, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(8'h70, VEC[i][76:69]);
      rd("R2", 8'h70, VEC[i][76:69] & 8'hFE);
      look($sformatf("R3-8 vec %0d", i), VEC[i][68], VEC[i][67:36], VEC[i][35:32], VEC[i][31:0]);
    end

    wr(8'h70, 8'h00);
    wr(8'h52, 8'hAB);
    wr(8'h54, 8'hFF);
    rd("R11", 8'h52, 8'hAB);
    rd("R11", 8'h54, 8'h0F);
    wr(8'h70, 8'h26);
    rd("R2", 8'h70, 8'h26);
    wr(8'h70, 8'hF9);
    rd("R9", 8'h70, 8'h22);
    look("R9", 1'b1, 32'h080F_FFFF, 4'b0010, 32'h080F_FFFF);
    look("R9", 1'b1, 32'h000A_0000, 4'b0000, 32'h0);
    wr(8'h70, 8'h04);
    rd("R10", 8'h70, 8'h26);
    look("R9", 1'b0, 32'h000A_0000, 4'b1000, 32'h000A_0000);
    wr(8'h70, 8'h00);
    rd("R10", 8'h70, 8'h22);
    wr(8'h52, 8'h11);
    wr(8'h54, 8'h03);
    rd("R11", 8'h52, 8'hAB);
    rd("R11", 8'h54, 8'h0F);

    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd("R1", 8'h70, 8'h00);
    rd("R1", 8'h52, 8'h00);
    look("R1", 1'b1, 32'h0800_0000, 4'b0000, 32'h0);
    wr(8'h70, 8'h04);
    rd("R10", 8'h70, 8'h04);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule